// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block decodes one external device window on a 24-bit address bus and drives an active-low select pin for it. Software programs three things through a small write port: a base word (upper address bits plus a window size code), an option word (byte lane, direction, strobe timing, termination, address space, interrupt level, autovector), and a pin word (pin use plus one discrete output bit). During a bus cycle the channel qualifies the address with every option field. On a hit it pulls the select low and, after the programmed number of wait states, returns a data-size acknowledge sized to the port width.

The same pin can be a plain output bit, or it can pass an alternate signal from elsewhere in the chip. In both of those uses the decoder is bypassed.

Top module: `csgen_channel`

## Requirements
- R1: While reset is low, and after it is released with no configuration written, csPinN is 1, ackN is 2'b11 and avecN is 1. Reset selects pin use 00 and sets the discrete bit to 1.
- R2: With pin use 00 (pin word bits 1:0), csPinN equals the discrete bit (pin word bit 2). A matching bus cycle then leaves ackN at 2'b11 and avecN at 1.
- R3: With pin use 01, csPinN follows altFuncIn combinationally and no acknowledge is produced.
- R4: With pin use 10 or 11 and a non-CPU space, a hit needs busAddr[23:k] to equal base word bits 15:(k-8). The size code in base bits 2:0 gives k: 0→11, 1→13, 2→14, 3→16, 4→17, 5→18, 6→19, 7→20. Address bits below k are ignored. csPinN falls at the first rising edge at which the hit is sampled.
- R5: Option bits 12:11 gate the access direction. 00 never matches, 01 matches reads (busRead=1) only, 10 matches writes only, 11 matches both.
- R6: Option bits 14:13 gate the byte lanes, and 00 never matches. With option bit 10 = 0 the select needs only asN low. With bit 10 = 1 it also needs a low strobe on an enabled lane: 01 uses ldsN, 10 uses udsN, 11 uses either.
- R7: Option bits 5:4 gate the space. 01 matches user cycles (spaceCpu=0, spaceSuper=0), 10 matches supervisor cycles (spaceCpu=0, spaceSuper=1), 11 matches any non-CPU cycle.
- R8: With space 00 only CPU-space cycles match. The base address is not compared. Option bits 3:1 must equal busAddr[3:1] unless they are 0. When option bit 0 is 1, avecN is driven low in place of ackN.
- R9: With termination code W = option bits 9:6 in 0..13, the acknowledge appears W+1 rising edges after the edge that lowered csPinN. ackN is 2'b10 for pin use 10 and 2'b00 for pin use 11.
- R10: Code 14 raises the acknowledge on the same edge that lowers csPinN.
- R11: Code 15 lowers csPinN but never produces an internal acknowledge.
- R12: At the first rising edge at which the cycle no longer qualifies, csPinN, ackN and avecN return to 1, 2'b11 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Target: 0 base word, 1 option word, 2 pin word |
| cfgWrData | input | 16 | Configuration write data |
| busAddr | input | 24 | Bus address |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper byte strobe, active low |
| ldsN | input | 1 | Lower byte strobe, active low |
| busRead | input | 1 | 1 for a read cycle, 0 for a write |
| spaceCpu | input | 1 | Cycle is in CPU space (acknowledge cycle) |
| spaceSuper | input | 1 | Cycle is a supervisor access |
| altFuncIn | input | 1 | Signal routed to the pin in alternate use |
| csPinN | output | 1 | Select pin, active low |
| ackN | output | 2 | Data-size acknowledge, active low |
| avecN | output | 1 | Autovector request, active low |

## Verification
Qualification is sampled on a rising edge, so the select changes one edge after the bus inputs that produce it. With code W the acknowledge follows W+1 edges later, or on that same edge for code 14. Release happens on the first edge that sees the cycle end. The discrete and alternate pin paths have no register between input and output. The bench changes inputs on falling edges, updates a behavioural model (a running age count since the select began) on each rising edge, and compares all three outputs 2 ns after that edge, when every register has settled. Each compare is tagged with the requirement the current stimulus targets, and the two idle cycles after each bus cycle are tagged R12.

// File: rtl/csgen_pkg.sv
package csgen_pkg;
  localparam int BLK_MIN_LOG2 = 11;
  localparam int SIZE_CODE_W  = 3;
  localparam int OPT_W        = 15;
  localparam int TERM_W       = 4;

  localparam logic [TERM_W-1:0] TERM_FAST = 4'd14;
  localparam logic [TERM_W-1:0] TERM_EXT  = 4'd15;

  typedef enum logic [1:0] {
    PIN_DISCRETE = 2'b00,
    PIN_ALT      = 2'b01,
    PIN_CS8      = 2'b10,
    PIN_CS16     = 2'b11
  } pinMode_e;

  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_OPT  = 2'd1,
    CFG_PIN  = 2'd2
  } cfgSel_e;

  typedef struct packed {
    logic selOn;
    logic ackOn;
  } ctlStrobe_t;

  // log2 of the window size for each size code
  function automatic int blkShift(input logic [SIZE_CODE_W-1:0] code);
    case (code)
      3'd0: return 11;
      3'd1: return 13;
      3'd2: return 14;
      3'd3: return 16;
      3'd4: return 17;
      3'd5: return 18;
      3'd6: return 19;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/csgen_datapath.sv
module csgen_datapath
  import csgen_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int BASE_W = ADDR_W - BLK_MIN_LOG2,
  localparam int CFG_W  = BASE_W + SIZE_CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              asN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic              busRead,
  input  logic              spaceCpu,
  input  logic              spaceSuper,
  input  logic              altFuncIn,
  input  ctlStrobe_t        ctl,
  output logic              hit,
  output logic [TERM_W-1:0] ackCode,
  output logic              csPinN,
  output logic [1:0]        ackN,
  output logic              avecN
);
  logic [CFG_W-1:0]  baseReg;
  logic [OPT_W-1:0]  optReg;
  pinMode_e          pinMode;
  logic              discBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      optReg  <= '0;
      pinMode <= PIN_DISCRETE;
      discBit <= 1'b1;
    end else if (cfgWrEn) begin
      case (cfgSel_e'(cfgSel))
        CFG_BASE: baseReg <= cfgWrData;
        CFG_OPT:  optReg  <= cfgWrData[OPT_W-1:0];
        CFG_PIN: begin
          pinMode <= pinMode_e'(cfgWrData[1:0]);
          discBit <= cfgWrData[2];
        end
        default: ;
      endcase
    end
  end

  // option fields
  logic [1:0] laneField, dirField, spaceField;
  logic       dsTimed, avecReq;
  logic [2:0] levelField;
  assign laneField  = optReg[14:13];
  assign dirField   = optReg[12:11];
  assign dsTimed    = optReg[10];
  assign ackCode    = optReg[9:6];
  assign spaceField = optReg[5:4];
  assign levelField = optReg[3:1];
  assign avecReq    = optReg[0];

  logic isCs;
  assign isCs = (pinMode == PIN_CS8) || (pinMode == PIN_CS16);

  // address window compare with size mask
  logic [SIZE_CODE_W-1:0] sizeCode;
  logic [BASE_W-1:0]      baseHi, keepMask, addrHi;
  logic                   addrEq;
  assign sizeCode = baseReg[SIZE_CODE_W-1:0];
  assign baseHi   = baseReg[CFG_W-1:SIZE_CODE_W];
  assign addrHi   = busAddr[ADDR_W-1:BLK_MIN_LOG2];

  always_comb begin
    for (int i = 0; i < BASE_W; i++) begin
      keepMask[i] = ((i + BLK_MIN_LOG2) >= blkShift(sizeCode));
    end
  end
  assign addrEq = ~|((addrHi ^ baseHi) & keepMask);

  logic unusedAddrBits;
  assign unusedAddrBits = ^{busAddr[BLK_MIN_LOG2-1:4], busAddr[0]};

  logic laneOk, dirOk, spaceOk, levelOk, addrOk;

  always_comb begin
    if (laneField == 2'b00) laneOk = 1'b0;
    else if (!dsTimed)      laneOk = 1'b1;
    else begin
      case (laneField)
        2'b01:   laneOk = !ldsN;
        2'b10:   laneOk = !udsN;
        default: laneOk = !ldsN || !udsN;
      endcase
    end
  end

  always_comb begin
    case (dirField)
      2'b00:   dirOk = 1'b0;
      2'b01:   dirOk = busRead;
      2'b10:   dirOk = !busRead;
      default: dirOk = 1'b1;
    endcase
  end

  assign levelOk = (levelField == 3'd0) || (busAddr[3:1] == levelField);

  always_comb begin
    case (spaceField)
      2'b00:   spaceOk = spaceCpu && levelOk;
      2'b01:   spaceOk = !spaceCpu && !spaceSuper;
      2'b10:   spaceOk = !spaceCpu && spaceSuper;
      default: spaceOk = !spaceCpu;
    endcase
  end

  assign addrOk = (spaceField == 2'b00) ? 1'b1 : addrEq;
  assign hit    = isCs && !asN && laneOk && dirOk && spaceOk && addrOk;

  // pin and acknowledge drive
  logic avecMode;
  assign avecMode = avecReq && (spaceField == 2'b00);

  always_comb begin
    case (pinMode)
      PIN_DISCRETE: csPinN = discBit;
      PIN_ALT:      csPinN = altFuncIn;
      default:      csPinN = !ctl.selOn;
    endcase
  end

  always_comb begin
    ackN  = 2'b11;
    avecN = 1'b1;
    if (ctl.ackOn && isCs) begin
      if (avecMode)                  avecN = 1'b0;
      else if (pinMode == PIN_CS16)  ackN  = 2'b00;
      else                           ackN  = 2'b10;
    end
  end
endmodule

// File: rtl/csgen_control.sv
module csgen_control
  import csgen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hit,
  input  logic [TERM_W-1:0] ackCode,
  output ctlStrobe_t        ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_HOLD} state_e;

  state_e            state;
  logic [TERM_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hit) begin
            if (ackCode == TERM_FAST)     state <= ST_ACK;
            else if (ackCode == TERM_EXT) state <= ST_HOLD;
            else begin
              waitCnt <= ackCode;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!hit)               state   <= ST_IDLE;
          else if (waitCnt == '0) state   <= ST_ACK;
          else                    waitCnt <= waitCnt - 1'b1;
        end
        default: begin
          if (!hit) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign ctl.selOn = (state != ST_IDLE);
  assign ctl.ackOn = (state == ST_ACK);
endmodule

// File: rtl/csgen_channel.sv
module csgen_channel
  import csgen_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       cfgWrEn,
  input  logic [1:0]                                 cfgSel,
  input  logic [ADDR_W-BLK_MIN_LOG2+SIZE_CODE_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0]                          busAddr,
  input  logic                                       asN,
  input  logic                                       udsN,
  input  logic                                       ldsN,
  input  logic                                       busRead,
  input  logic                                       spaceCpu,
  input  logic                                       spaceSuper,
  input  logic                                       altFuncIn,
  output logic                                       csPinN,
  output logic [1:0]                                 ackN,
  output logic                                       avecN
);
  ctlStrobe_t        ctl;
  logic              hit;
  logic [TERM_W-1:0] ackCode;

  csgen_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk, .rstN, .cfgWrEn, .cfgSel, .cfgWrData, .busAddr, .asN, .udsN,
    .ldsN, .busRead, .spaceCpu, .spaceSuper, .altFuncIn, .ctl, .hit,
    .ackCode, .csPinN, .ackN, .avecN
  );

  csgen_control u_ctl (
    .clk, .rstN, .hit, .ackCode, .ctl
  );
endmodule

// File: rtl/csgen_channel_sva.sv
module csgen_channel_sva (
  input logic       clk,
  input logic       rstN,
  input logic       hit,
  input logic [3:0] ackCode,
  input logic       selOn,
  input logic       ackOn,
  input logic       csPinN,
  input logic [1:0] ackN,
  input logic       avecN
);
  logic seenEdge;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R1: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rstN && seenEdge === 1'b1)
      a_r1_reset_quiet: assert (csPinN && ackN == 2'b11 && avecN);
  end

  a_r4_hit_starts_select: assert property (@(posedge clk) disable iff (!rstN)
    (!selOn && hit) |=> selOn);

  a_r12_drop_releases: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> (!selOn && !ackOn));

  a_r10_fast_same_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!selOn && hit && ackCode == 4'd14) |=> ackOn);

  a_r11_external_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!selOn && hit && ackCode == 4'd15) |=> (selOn && !ackOn));

  a_r9_ack_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    ackOn |-> selOn);

  a_r9_ack_lane_code: assert property (@(posedge clk) disable iff (!rstN)
    (ackN != 2'b11) |-> (ackN[0] == 1'b0 && avecN));

  a_r8_avec_alone: assert property (@(posedge clk) disable iff (!rstN)
    !avecN |-> (ackN == 2'b11 && !csPinN));
endmodule

bind csgen_channel csgen_channel_sva u_sva (
  .clk(clk), .rstN(rstN), .hit(hit), .ackCode(ackCode),
  .selOn(ctl.selOn), .ackOn(ctl.ackOn), .csPinN(csPinN),
  .ackN(ackN), .avecN(avecN)
);

// File: tb/tb_csgen_channel.sv
module tb_csgen_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [15:0] cfgWrData = 16'd0;
  logic [23:0] busAddr = 24'd0;
  logic        asN = 1'b1, udsN = 1'b1, ldsN = 1'b1;
  logic        busRead = 1'b1, spaceCpu = 1'b0, spaceSuper = 1'b0;
  logic        altFuncIn = 1'b0;
  logic        csPinN, avecN;
  logic [1:0]  ackN;

  csgen_channel dut (
    .clk, .rstN, .cfgWrEn, .cfgSel, .cfgWrData, .busAddr, .asN, .udsN,
    .ldsN, .busRead, .spaceCpu, .spaceSuper, .altFuncIn, .csPinN, .ackN,
    .avecN
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curReq = "R1";

  // behavioural model state
  logic [15:0] mBase, mOpt;
  logic [1:0]  mPin;
  logic        mDisc;
  bit          mSel;
  int          mAge;

  function automatic int blkBytes(input logic [2:0] c);
    int kb [8] = '{2, 8, 16, 64, 128, 256, 512, 1024};
    return kb[c] * 1024;
  endfunction

  function automatic bit modelHit();
    int blk;
    if (mPin < 2'd2 || asN) return 1'b0;
    if (mOpt[14:13] == 2'b00) return 1'b0;
    if (mOpt[10]) begin
      if (mOpt[14:13] == 2'b01 && ldsN) return 1'b0;
      if (mOpt[14:13] == 2'b10 && udsN) return 1'b0;
      if (mOpt[14:13] == 2'b11 && ldsN && udsN) return 1'b0;
    end
    if (mOpt[12:11] == 2'b00) return 1'b0;
    if (mOpt[12:11] == 2'b01 && !busRead) return 1'b0;
    if (mOpt[12:11] == 2'b10 && busRead) return 1'b0;
    if (mOpt[5:4] == 2'b00) begin
      if (!spaceCpu) return 1'b0;
      if (mOpt[3:1] != 3'd0 && busAddr[3:1] != mOpt[3:1]) return 1'b0;
      return 1'b1;
    end
    if (spaceCpu) return 1'b0;
    if (mOpt[5:4] == 2'b01 && spaceSuper) return 1'b0;
    if (mOpt[5:4] == 2'b10 && !spaceSuper) return 1'b0;
    blk = blkBytes(mBase[2:0]);
    return (int'(busAddr) / blk) == (int'({mBase[15:3], 11'd0}) / blk);
  endfunction

  always @(posedge clk) begin
    bit          expAck, expAvec;
    logic        expCs;
    logic [1:0]  expAckN;
    int          code;
    cycles++;
    if (!rstN) begin
      mBase = '0; mOpt = '0; mPin = 2'b00; mDisc = 1'b1; mSel = 0; mAge = 0;
    end else begin
      if (modelHit()) begin
        if (!mSel) begin mSel = 1; mAge = 0; end
        else mAge++;
      end else begin
        mSel = 0;
      end
      if (cfgWrEn) begin
        if (cfgSel == 2'd0) mBase = cfgWrData;
        else if (cfgSel == 2'd1) mOpt = {1'b0, cfgWrData[14:0]};
        else if (cfgSel == 2'd2) begin mPin = cfgWrData[1:0]; mDisc = cfgWrData[2]; end
      end
    end
    #2;
    code    = int'(mOpt[9:6]);
    expAck  = mSel && mPin >= 2'd2 && (code == 14 || (code <= 13 && mAge >= code + 1));
    expAvec = expAck && mOpt[0] && mOpt[5:4] == 2'b00;
    expAckN = (expAck && !expAvec) ? ((mPin == 2'b11) ? 2'b00 : 2'b10) : 2'b11;
    expCs   = (mPin == 2'b00) ? mDisc : (mPin == 2'b01) ? altFuncIn : !mSel;
    checks++;
    if (csPinN !== expCs || ackN !== expAckN || avecN !== !expAvec) begin
      errors++;
      $display("FAIL %s: cs=%b ack=%b avec=%b expected cs=%b ack=%b avec=%b",
               curReq, csPinN, ackN, avecN, expCs, expAckN, !expAvec);
    end
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] mkOpt(input logic [1:0] lane, input logic [1:0] rw,
                                        input logic ds, input logic [3:0] term,
                                        input logic [1:0] sp, input logic [2:0] lvl,
                                        input logic av);
    return {1'b0, lane, rw, ds, term, sp, lvl, av};
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [15:0] data);
    cfgSel = sel; cfgWrData = data; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic busCycle(input logic [23:0] addr, input logic rd, input logic cpu,
                          input logic sup, input logic u, input logic l, input int hold);
    string saved;
    busAddr = addr; busRead = rd; spaceCpu = cpu; spaceSuper = sup;
    asN = 1'b0; udsN = u; ldsN = l;
    repeat (hold) @(negedge clk);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    saved = curReq; curReq = "R12";
    repeat (2) @(negedge clk);
    curReq = saved;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // 64K window at 0x120000, any direction, AS timing, 2 waits, any non-CPU space
    cfgWrite(2'd0, 16'h1203);
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd2, 2'b11, 3'd0, 1'b0));

    curReq = "R2";
    cfgWrite(2'd2, 16'h0000);
    busCycle(24'h12ABCD, 1, 0, 0, 0, 0, 5);
    cfgWrite(2'd2, 16'h0004);
    busCycle(24'h12ABCD, 1, 0, 0, 0, 0, 5);

    curReq = "R3";
    cfgWrite(2'd2, 16'h0001);
    altFuncIn = 1'b1; @(negedge clk);
    altFuncIn = 1'b0; @(negedge clk);
    busCycle(24'h12ABCD, 1, 0, 0, 0, 0, 4);

    curReq = "R4";
    cfgWrite(2'd2, 16'h0003);
    busCycle(24'h12ABCD, 1, 0, 0, 0, 0, 6);
    busCycle(24'h130000, 1, 0, 0, 0, 0, 4);
    busCycle(24'h11FFFF, 1, 0, 0, 0, 0, 4);
    cfgWrite(2'd0, 16'h1007);
    busCycle(24'h1FFFFE, 0, 0, 1, 0, 0, 5);
    busCycle(24'h200000, 0, 0, 1, 0, 0, 4);

    curReq = "R5";
    cfgWrite(2'd1, mkOpt(2'b11, 2'b01, 1'b0, 4'd1, 2'b11, 3'd0, 1'b0));
    busCycle(24'h100040, 0, 0, 0, 0, 0, 4);
    busCycle(24'h100040, 1, 0, 0, 0, 0, 4);
    cfgWrite(2'd1, mkOpt(2'b11, 2'b10, 1'b0, 4'd1, 2'b11, 3'd0, 1'b0));
    busCycle(24'h100040, 1, 0, 0, 0, 0, 4);
    busCycle(24'h100040, 0, 0, 0, 0, 0, 4);

    curReq = "R6";
    cfgWrite(2'd1, mkOpt(2'b00, 2'b11, 1'b0, 4'd1, 2'b11, 3'd0, 1'b0));
    busCycle(24'h100040, 1, 0, 0, 0, 0, 4);
    cfgWrite(2'd1, mkOpt(2'b01, 2'b11, 1'b1, 4'd1, 2'b11, 3'd0, 1'b0));
    busCycle(24'h100040, 1, 0, 0, 0, 1, 4);
    busCycle(24'h100040, 1, 0, 0, 1, 0, 4);
    cfgWrite(2'd1, mkOpt(2'b10, 2'b11, 1'b1, 4'd1, 2'b11, 3'd0, 1'b0));
    busCycle(24'h100040, 1, 0, 0, 1, 0, 4);
    busCycle(24'h100040, 1, 0, 0, 0, 1, 4);

    curReq = "R7";
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd0, 2'b10, 3'd0, 1'b0));
    busCycle(24'h100040, 1, 0, 0, 0, 0, 4);
    busCycle(24'h100040, 1, 0, 1, 0, 0, 4);
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd0, 2'b01, 3'd0, 1'b0));
    busCycle(24'h100040, 1, 0, 1, 0, 0, 4);
    busCycle(24'h100040, 1, 0, 0, 0, 0, 4);
    busCycle(24'h100040, 1, 1, 0, 0, 0, 4);

    curReq = "R8";
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd1, 2'b00, 3'd5, 1'b1));
    busCycle(24'hFFFFFA, 1, 1, 1, 0, 0, 5);
    busCycle(24'hFFFFF6, 1, 1, 1, 0, 0, 5);
    busCycle(24'hFFFFFA, 1, 0, 1, 0, 0, 4);
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd1, 2'b00, 3'd0, 1'b0));
    busCycle(24'hFFFFF6, 1, 1, 1, 0, 0, 5);

    curReq = "R9";
    cfgWrite(2'd2, 16'h0002);
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
    busCycle(24'h1ABCDE, 1, 0, 0, 0, 0, 5);
    cfgWrite(2'd2, 16'h0003);
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd13, 2'b11, 3'd0, 1'b0));
    busCycle(24'h1ABCDE, 1, 0, 0, 0, 0, 18);

    curReq = "R10";
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd14, 2'b11, 3'd0, 1'b0));
    busCycle(24'h1ABCDE, 0, 0, 0, 0, 0, 4);

    curReq = "R11";
    cfgWrite(2'd1, mkOpt(2'b11, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0));
    busCycle(24'h1ABCDE, 0, 0, 0, 0, 0, 8);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule